// File: doc/BRIEF.md
# Pipelined Single-Port SRAM with Delayed Write Data

This block is a synchronous single-port memory model with a two-stage command pipeline. Each rising clock edge samples an address and two active-low strobes, one for read and one for write. A read returns its word on the registered data output one edge after the command edge. A write takes its data from the write-data bus one cycle later than a read would deliver data, two edges after the command edge. Read and write therefore sit at the same pipeline offset on the data side. A controller can issue any mix of reads and writes on consecutive edges without inserting idle cycles.

The block holds the address of the write whose data has not yet arrived. A read issued on the edge right after a write to the same address takes the arriving write data straight from the bus instead of the stale stored word. Two strobes low together is an illegal command. It does no access and raises an error flag for one cycle. A synchronous active-low reset clears the pipeline, the output register and the flag, and leaves the stored words untouched. Depth is set by the address-width parameter. A width of 16 gives 65,536 words. The default is smaller so that the model stays light to elaborate.

Top module: `late_write_sram`

## Requirements
- R1: The command is `{rd_n, wr_n}`. The value 01 is a read. For a read sampled at edge N, `rdata` carries the addressed word from edge N+1 until it is next updated.
- R2: The value 10 is a write. For a write sampled at edge N, the word stored is the value of `wdata` at edge N+2. Values of `wdata` at every other edge have no effect on the stored contents.
- R3: Reads and writes may be issued on every consecutive edge in any order. Every read returns the data of the most recent write to its address that was sampled before it.
- R4: A read sampled at edge N+1 to the address of a write sampled at edge N returns that write's data, which is the value of `wdata` at edge N+2.
- R5: The value 00 is illegal. It does no access and sets `cmd_err` high for exactly the cycle after its edge. `cmd_err` is low in every other cycle.
- R6: `rdata` keeps its value at every edge that does not complete a read.
- R7: A low `rst_n` at an edge clears `rdata` to zero and `cmd_err` to low, and discards the commands in flight. Words that were already stored keep their values.
- R8: The value 11 is a no-operation. It changes no stored word and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of control state |
| addr | input | ADDR_W | Word address of the command |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | DATA_W | Write data, sampled two edges after its write command |
| rdata | output | DATA_W | Registered read data |
| cmd_err | output | 1 | One-cycle flag for an illegal command |

## Verification
The bench aims at the hazards. The sharpest case is a read issued on the edge right after a write to the same address. A design without forwarding returns the old word there, and a design that forwards from the wrong stage returns a neighbouring write's data. Back-to-back write, read, read, read, write patterns on a handful of addresses catch a design that commits at the wrong edge. Such a design stores whatever `wdata` happened to carry on another cycle, because that bus carries fresh noise every cycle. Runs of no-operations and illegal commands show whether `rdata` drifts or an illegal command writes anything. A reset in the middle of a run, followed by read-back, shows whether reset wipes the stored contents.

// File: rtl/lws_pkg.sv
package lws_pkg;
  // Strobe pair {rd_n, wr_n} as sampled on the rising edge
  typedef enum logic [1:0] {
    CMD_ILLEGAL = 2'b00,
    CMD_READ    = 2'b01,
    CMD_WRITE   = 2'b10,
    CMD_IDLE    = 2'b11
  } lws_cmd_e;
endpackage

// File: rtl/lws_decode.sv
module lws_decode
  import lws_pkg::*;
(
  input  logic rd_n,
  input  logic wr_n,
  output logic is_rd,
  output logic is_wr,
  output logic is_ill
);
  lws_cmd_e cmd;

  always_comb begin
    cmd    = lws_cmd_e'({rd_n, wr_n});
    is_rd  = 1'b0;
    is_wr  = 1'b0;
    is_ill = 1'b0;
    unique case (cmd)
      CMD_READ:    is_rd  = 1'b1;
      CMD_WRITE:   is_wr  = 1'b1;
      CMD_ILLEGAL: is_ill = 1'b1;
      default:     ;
    endcase
  end
endmodule

// File: rtl/lws_pipe.sv
module lws_pipe #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_rd,
  input  logic              is_wr,
  input  logic              is_ill,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_go,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wb_go,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              fwd_hit,
  output logic              cmd_err
);
  // stage 1: command just sampled; stage 2: write waiting for its data
  logic              s1_rd_q, s1_rd_d;
  logic              s1_wr_q, s1_wr_d;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_d;
  logic              s1_addr_en;
  logic              s2_wr_q, s2_wr_d;
  logic [ADDR_W-1:0] s2_addr_q, s2_addr_d;
  logic              s2_addr_en;
  logic              err_q, err_d;

  always_comb begin
    s1_rd_d    = is_rd;
    s1_wr_d    = is_wr;
    s1_addr_en = is_rd | is_wr;
    s1_addr_d  = s1_addr_en ? addr : s1_addr_q;
    s2_wr_d    = s1_wr_q;
    s2_addr_en = s1_wr_q;
    s2_addr_d  = s2_addr_en ? s1_addr_q : s2_addr_q;
    err_d      = is_ill;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_rd_q <= 1'b0;
      s1_wr_q <= 1'b0;
      s2_wr_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      s1_rd_q <= s1_rd_d;
      s1_wr_q <= s1_wr_d;
      s2_wr_q <= s2_wr_d;
      err_q   <= err_d;
    end
  end

  // address registers: enable only, no reset needed
  always_ff @(posedge clk) begin
    s1_addr_q <= s1_addr_d;
    s2_addr_q <= s2_addr_d;
  end

  assign rd_go   = s1_rd_q;
  assign rd_addr = s1_addr_q;
  assign wb_go   = s2_wr_q;
  assign wb_addr = s2_addr_q;
  assign fwd_hit = s1_rd_q & s2_wr_q & (s1_addr_q == s2_addr_q);
  assign cmd_err = err_q;
endmodule

// File: rtl/lws_store.sv
module lws_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wword,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wword;
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/lws_readout.sv
module lws_readout #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              fwd_hit,
  input  logic [DATA_W-1:0] arr_word,
  input  logic [DATA_W-1:0] bus_word,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_q, rdata_d, pick;

  always_comb begin
    pick    = fwd_hit ? bus_word : arr_word;
    rdata_d = rd_go ? pick : rdata_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/late_write_sram.sv
module late_write_sram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              cmd_err
);
  logic              is_rd, is_wr, is_ill;
  logic              rd_go, wb_go, fwd_hit, commit;
  logic [ADDR_W-1:0] rd_addr, wb_addr;
  logic [DATA_W-1:0] arr_word;

  lws_decode u_dec (
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .is_rd  (is_rd),
    .is_wr  (is_wr),
    .is_ill (is_ill)
  );

  lws_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .is_rd   (is_rd),
    .is_wr   (is_wr),
    .is_ill  (is_ill),
    .addr    (addr),
    .rd_go   (rd_go),
    .rd_addr (rd_addr),
    .wb_go   (wb_go),
    .wb_addr (wb_addr),
    .fwd_hit (fwd_hit),
    .cmd_err (cmd_err)
  );

  // a write still in flight at a reset edge is discarded
  assign commit = wb_go & rst_n;

  lws_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (commit),
    .waddr (wb_addr),
    .wword (wdata),
    .raddr (rd_addr),
    .rword (arr_word)
  );

  lws_readout #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_go    (rd_go),
    .fwd_hit  (fwd_hit),
    .arr_word (arr_word),
    .bus_word (wdata),
    .rdata    (rdata)
  );
endmodule

// File: rtl/lws_chk.sv
module lws_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              cmd_err
);
  // R5
  illegal_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |=> cmd_err);

  // R5
  legal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n) |=> !cmd_err);

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && wr_n) |-> ##2 $stable(rdata));

  // R4
  fwd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && wr_n && $past(rst_n) && $past(rd_n) && !$past(wr_n)
     && addr == $past(addr)) |=> ##1 (rdata == $past(wdata)));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (rdata == '0 && !cmd_err));
endmodule

bind late_write_sram lws_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_late_write_sram.sv
module tb_late_write_sram;
  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          cmd_err;

  late_write_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .wdata(wdata), .rdata(rdata), .cmd_err(cmd_err)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    started = 0;
  bit    done = 0;
  string tag = "R7";

  // behavioural reference
  logic [DW-1:0] ref_mem [DEPTH];
  bit            m_rd1, m_wr1, m_wr2, exp_err;
  int            m_a1, m_a2;
  logic [DW-1:0] exp_rdata;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_rd1 = 0; m_wr1 = 0; m_wr2 = 0; exp_err = 0; exp_rdata = '0;
    end else begin
      if (m_rd1) exp_rdata = (m_wr2 && m_a2 == m_a1) ? wdata : ref_mem[m_a1];
      if (m_wr2) ref_mem[m_a2] = wdata;
      m_wr2 = m_wr1;
      m_a2  = m_a1;
      m_rd1 = !rd_n && wr_n;
      m_wr1 = rd_n && !wr_n;
      m_a1  = int'(addr);
      exp_err = !rd_n && !wr_n;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (rdata !== exp_rdata) begin
        errors++;
        $display("FAIL %s rdata actual %h expected %h at t=%0t", tag, rdata, exp_rdata, $time);
      end
      checks++;
      if (cmd_err !== exp_err) begin
        errors++;
        $display("FAIL R5 cmd_err actual %b expected %b at t=%0t", cmd_err, exp_err, $time);
      end
    end
  end

  task automatic issue(input logic r, input logic w, input int a);
    @(negedge clk);
    rd_n  = r;
    wr_n  = w;
    addr  = AW'(a);
    wdata = $urandom;
  endtask

  task automatic rd(input int a);  issue(1'b0, 1'b1, a); endtask
  task automatic wr(input int a);  issue(1'b1, 1'b0, a); endtask
  task automatic nop();            issue(1'b1, 1'b1, 0); endtask
  task automatic ill(input int a); issue(1'b0, 1'b0, a); endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    // R7: reset state
    tag = "R7";
    repeat (12) @(negedge clk);
    rst_n = 1'b1;
    // R2: fill every word back to back, wdata noisy each cycle
    tag = "R2";
    for (int i = 0; i < DEPTH; i++) wr(i);
    nop(); nop();
    // R1: plain reads, with nops in between for R6
    tag = "R1";
    for (int i = 0; i < 40; i++) rd(i * 7);
    tag = "R6";
    for (int i = 0; i < 10; i++) begin rd(i); nop(); nop(); end
    // R8: nops change nothing
    tag = "R8";
    repeat (8) nop();
    for (int i = 0; i < 8; i++) rd(i);
    // R3: write A, read B, read C, read D, write E patterns
    tag = "R3";
    for (int k = 0; k < 30; k++) begin
      wr(k % 4); rd((k + 1) % 4); rd((k + 2) % 4); rd(k % 4); wr((k + 3) % 4);
    end
    // R4: read right after write to the same address, and chains
    tag = "R4";
    for (int k = 0; k < 20; k++) begin
      wr(k); rd(k); wr(k); wr(k); rd(k); rd(k);
    end
    // R5: illegal commands mixed in, followed by reads of the same address
    tag = "R5";
    for (int k = 0; k < 12; k++) begin
      ill(k); rd(k); ill(k + 1); ill(k + 1); nop(); rd(k + 1);
    end
    // R3: random mix on few addresses
    tag = "R3";
    for (int k = 0; k < 3000; k++) begin
      int sel = $urandom_range(0, 9);
      int a   = $urandom_range(0, 7);
      if (sel < 4)      rd(a);
      else if (sel < 8) wr(a);
      else if (sel < 9) nop();
      else              ill(a);
    end
    // R7: reset mid-run keeps contents
    nop(); nop(); nop();
    tag = "R7";
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) rd(i);
    nop(); nop(); nop();
    @(negedge clk);
    finish_run();
  end
endmodule